// File: doc/BRIEF.md
# Instruction Prefix Scanner

The scanner is the first stage of a variable-length instruction decoder. Instruction bytes arrive one per cycle, qualified by a valid strobe. It takes in legacy prefixes, a REX byte and an optional VEX-style prefix with its payload, and builds up a prefix summary as it goes. When the opcode byte arrives, it reports that byte, the summary and a set of derived flags in a single-cycle output pulse. It then starts a fresh summary for the next instruction.

Odd or repeated prefix combinations pass without complaint, in the same way real silicon accepts them. Repeats, conflicting segment overrides and legacy bytes after REX are all accepted, and a REP that does nothing is only flagged. LOCK is the one prefix that is checked strictly. For a lockable opcode, the scanner also takes in the next byte as ModRM so it can tell a register operand from a memory operand. A VEX prefix always closes the prefix run. A length limit stops a runaway prefix chain.

Top module: `prefix_scanner`

## Requirements
- R1: The following bytes are legacy prefixes: F0 (lock), F2 (repne), F3 (rep), 26/2E/36/3E/64/65 (segment), 66 (operand size) and 67 (address size). Any of them may repeat any number of times without error. The result pulses `out_valid_o` for one cycle, in the cycle after the opcode byte is accepted. `opsize_o` and `addrsize_o` report whether 66 and 67 were seen.
- R2: When several segment prefixes appear, the last one wins. `seg_o` encodes it as 0 none, 1 ES(26), 2 CS(2E), 3 SS(36), 4 DS(3E), 5 FS(64), 6 GS(65).
- R3: Between F2 and F3 the last one seen wins. `rep_o` encodes it as 0 none, 1 F2, 2 F3.
- R4: When `mode64_i`=1, bytes 40–4F are REX prefixes. `rex_vld_o`=1 and `rex_o` gives the low nibble only when the REX byte is the last prefix before the opcode. A later legacy prefix clears it, and a later REX replaces it. When `mode64_i`=0, bytes 40–4F are opcodes.
- R5: C5 starts a two-byte VEX prefix: `vex_o`=2, and the single payload byte goes to `vex_payload_o[7:0]`. C4 starts a three-byte VEX prefix: `vex_o`=3, and the payload goes to `vex_payload_o` as {first, second}. The byte after the payload is always the opcode, whatever its value. VEX clears any REX.
- R6: `rep_ignored_o`=1 when `rep_o`≠0, there is no VEX, the result is not a pause, and the opcode is not a string opcode (6C–6F, A4–A7, AA–AF).
- R7: F3 as the winning repeat prefix, with no VEX and opcode 90, gives `pause_o`=1 and `rep_ignored_o`=0.
- R8: A segment prefix before an opcode in 70–7F with no VEX gives `branch_hint_o`=1 and `seg_o`=0.
- R9: With lock seen, the result has `lock_invalid_o`=1 and `modrm_vld_o`=0 in two cases: a VEX prefix is present, or the opcode is not lockable. The lockable opcodes are 00,01,08,09,10,11,18,19,20,21,28,29,30,31,80,81,83,86,87,F6,F7,FE,FF.
- R10: With lock seen and a lockable opcode without VEX, the next byte is taken in as ModRM. The result pulses in the cycle after that byte, with `modrm_vld_o`=1 and `modrm_o` holding the byte. `lock_invalid_o`=1 exactly when ModRM bits 7:6 are 11.
- R11: `len_o` counts the prefix, VEX and opcode bytes; it does not count ModRM. An opcode as the 15th byte is legal. If the 15th byte is not an opcode, the scanner emits a result with `too_long_o`=1 and `len_o`=15, clears every other field and restarts.
- R12: After reset, `out_valid_o`=0. Bytes with `valid_i`=0 are ignored. Every instruction starts from an empty summary, including after a reset in the middle of a prefix run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Instruction byte |
| mode64_i | input | 1 | 64-bit mode, enables REX |
| out_valid_o | output | 1 | Result pulse |
| opcode_o | output | 8 | Opcode byte |
| seg_o | output | 3 | Segment override code |
| rep_o | output | 2 | Repeat prefix code |
| lock_o | output | 1 | Lock prefix seen |
| lock_invalid_o | output | 1 | Lock rejected (undefined opcode) |
| rep_ignored_o | output | 1 | Repeat prefix has no effect |
| pause_o | output | 1 | Pause form detected |
| branch_hint_o | output | 1 | Segment prefix reused as branch hint |
| opsize_o | output | 1 | Operand-size prefix seen |
| addrsize_o | output | 1 | Address-size prefix seen |
| rex_vld_o | output | 1 | REX in effect |
| rex_o | output | 4 | REX W,R,X,B bits |
| vex_o | output | 2 | VEX form: 0 none, 2 two-byte, 3 three-byte |
| vex_payload_o | output | 16 | VEX payload bytes |
| modrm_vld_o | output | 1 | ModRM captured for lock check |
| modrm_o | output | 8 | Captured ModRM byte |
| len_o | output | 4 | Prefix plus opcode byte count |
| too_long_o | output | 1 | Length limit abort |

## Verification
The hardest case to reach is the length boundary. The abort must fire when the fifteenth byte is a prefix or a VEX payload byte, and must not fire when that byte is an opcode. The stimulus sends long runs of repeated 66 bytes ending at each side of the boundary. One run places a C5 so that its payload falls exactly on the limit. After the abort, the bench sends a short instruction and checks that none of the aborted summary carries over. A reset in the middle of a run, and idle gaps that hold an opcode-looking byte on the bus, show that only strobed bytes build up the summary.

// File: rtl/prefix_scan_pkg.sv
package prefix_scan_pkg;
  typedef enum logic [2:0] {SEG_NONE, SEG_ES, SEG_CS, SEG_SS, SEG_DS, SEG_FS, SEG_GS} seg_e;
  typedef enum logic [1:0] {REP_NONE = 2'd0, REP_NE = 2'd1, REP_E = 2'd2} rep_e;
  typedef enum logic [1:0] {VEX_NONE = 2'd0, VEX_TWO = 2'd2, VEX_THREE = 2'd3} vex_e;
  typedef enum logic [2:0] {CLS_OPC, CLS_SEG, CLS_REP, CLS_LOCK, CLS_OSZ, CLS_ASZ, CLS_REX, CLS_VEX} cls_e;

  typedef struct packed {
    seg_e        seg;
    rep_e        rep;
    logic        lock;
    logic        osz;
    logic        asz;
    logic        rexv;
    logic [3:0]  rex;
    vex_e        vex;
    logic [15:0] pay;
  } pfx_sum_t;

  typedef struct packed {
    logic [7:0] opc;
    pfx_sum_t   sum;
    logic       linv;
    logic       rign;
    logic       pau;
    logic       hint;
    logic       modv;
    logic [7:0] modrm;
  } scan_out_t;
endpackage

// File: rtl/prefix_class.sv
module prefix_class
  import prefix_scan_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic       mode64_i,
  output cls_e       cls_o,
  output seg_e       seg_o,
  output rep_e       rep_o
);
  always_comb begin
    cls_o = CLS_OPC;
    seg_o = SEG_NONE;
    rep_o = REP_NONE;
    case (byte_i)
      8'hF0: cls_o = CLS_LOCK;
      8'hF2: begin cls_o = CLS_REP; rep_o = REP_NE; end
      8'hF3: begin cls_o = CLS_REP; rep_o = REP_E;  end
      8'h26: begin cls_o = CLS_SEG; seg_o = SEG_ES; end
      8'h2E: begin cls_o = CLS_SEG; seg_o = SEG_CS; end
      8'h36: begin cls_o = CLS_SEG; seg_o = SEG_SS; end
      8'h3E: begin cls_o = CLS_SEG; seg_o = SEG_DS; end
      8'h64: begin cls_o = CLS_SEG; seg_o = SEG_FS; end
      8'h65: begin cls_o = CLS_SEG; seg_o = SEG_GS; end
      8'h66: cls_o = CLS_OSZ;
      8'h67: cls_o = CLS_ASZ;
      8'hC4, 8'hC5: cls_o = CLS_VEX;
      default: if (mode64_i && byte_i[7:4] == 4'h4) cls_o = CLS_REX;
    endcase
  end
endmodule

// File: rtl/opcode_attr.sv
module opcode_attr (
  input  logic [7:0] opc_i,
  output logic       lockable_o,
  output logic       string_o,
  output logic       jcc_o
);
  logic alu_rm;
  // r/m-destination ALU forms, CMP (38/39) excluded
  assign alu_rm = (opc_i[7:6] == 2'b00) && (opc_i[2:1] == 2'b00) && (opc_i[5:3] != 3'd7);

  always_comb begin
    case (opc_i)
      8'h80, 8'h81, 8'h83, 8'h86, 8'h87, 8'hF6, 8'hF7, 8'hFE, 8'hFF: lockable_o = 1'b1;
      default: lockable_o = alu_rm;
    endcase
  end

  assign string_o = (opc_i[7:2] == 6'b011011) || (opc_i[7:2] == 6'b101001) ||
                    (opc_i >= 8'hAA && opc_i <= 8'hAF);
  assign jcc_o    = (opc_i[7:4] == 4'h7);
endmodule

// File: rtl/prefix_scanner.sv
module prefix_scanner
  import prefix_scan_pkg::*;
#(
  parameter int unsigned MAX_LEN = 15,
  localparam int unsigned CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        byte_i,
  input  logic              mode64_i,
  output logic              out_valid_o,
  output logic [7:0]        opcode_o,
  output logic [2:0]        seg_o,
  output logic [1:0]        rep_o,
  output logic              lock_o,
  output logic              lock_invalid_o,
  output logic              rep_ignored_o,
  output logic              pause_o,
  output logic              branch_hint_o,
  output logic              opsize_o,
  output logic              addrsize_o,
  output logic              rex_vld_o,
  output logic [3:0]        rex_o,
  output logic [1:0]        vex_o,
  output logic [15:0]       vex_payload_o,
  output logic              modrm_vld_o,
  output logic [7:0]        modrm_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              too_long_o
);
  typedef enum logic [2:0] {ST_PFX, ST_VEX1, ST_VEX2, ST_VOP, ST_MODRM} st_e;

  st_e              st_q, st_d;
  pfx_sum_t         acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_n;
  logic [7:0]       hold_q, hold_d, opc_src;
  logic             emit, abort, opc_now, at_limit;
  cls_e             cls;
  seg_e             seg_c;
  rep_e             rep_c;
  logic             lockable, is_string, is_jcc;
  scan_out_t        out_d, out_q;
  logic             out_v_q, tl_q;
  logic [CNT_W-1:0] len_q;

  prefix_class u_class (
    .byte_i   (byte_i),
    .mode64_i (mode64_i),
    .cls_o    (cls),
    .seg_o    (seg_c),
    .rep_o    (rep_c)
  );

  assign opc_src = (st_q == ST_MODRM) ? hold_q : byte_i;

  opcode_attr u_attr (
    .opc_i      (opc_src),
    .lockable_o (lockable),
    .string_o   (is_string),
    .jcc_o      (is_jcc)
  );

  assign cnt_n    = cnt_q + 1'b1;
  assign at_limit = (cnt_n == CNT_W'(MAX_LEN));
  assign opc_now  = valid_i && ((st_q == ST_PFX && cls == CLS_OPC) || st_q == ST_VOP);

  always_comb begin
    st_d   = st_q;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    emit   = 1'b0;
    abort  = 1'b0;
    if (valid_i) begin
      if (opc_now) begin
        if (acc_q.lock && acc_q.vex == VEX_NONE && lockable) begin
          hold_d = byte_i;
          cnt_d  = cnt_n;
          st_d   = ST_MODRM;
        end else begin
          emit = 1'b1;
        end
      end else if (st_q == ST_MODRM) begin
        emit = 1'b1;
      end else if (at_limit) begin
        abort = 1'b1;
      end else begin
        cnt_d = cnt_n;
        case (st_q)
          ST_VEX1: begin acc_d.pay[15:8] = byte_i; st_d = ST_VEX2; end
          ST_VEX2: begin acc_d.pay[7:0]  = byte_i; st_d = ST_VOP;  end
          default: begin
            // REX only survives when nothing else follows it
            acc_d.rexv = 1'b0;
            acc_d.rex  = '0;
            case (cls)
              CLS_SEG:  acc_d.seg  = seg_c;
              CLS_REP:  acc_d.rep  = rep_c;
              CLS_LOCK: acc_d.lock = 1'b1;
              CLS_OSZ:  acc_d.osz  = 1'b1;
              CLS_ASZ:  acc_d.asz  = 1'b1;
              CLS_REX:  begin acc_d.rexv = 1'b1; acc_d.rex = byte_i[3:0]; end
              CLS_VEX:  begin
                acc_d.vex = byte_i[0] ? VEX_TWO : VEX_THREE;
                st_d      = byte_i[0] ? ST_VEX2 : ST_VEX1;
              end
              default: ;
            endcase
          end
        endcase
      end
      if (emit || abort) begin
        st_d  = ST_PFX;
        acc_d = '0;
        cnt_d = '0;
      end
    end
  end

  always_comb begin
    out_d       = '0;
    out_d.opc   = opc_src;
    out_d.sum   = acc_q;
    out_d.pau   = acc_q.rep == REP_E && acc_q.vex == VEX_NONE && opc_src == 8'h90;
    out_d.rign  = acc_q.rep != REP_NONE && acc_q.vex == VEX_NONE && !is_string && !out_d.pau;
    out_d.hint  = acc_q.seg != SEG_NONE && acc_q.vex == VEX_NONE && is_jcc;
    if (out_d.hint) out_d.sum.seg = SEG_NONE;
    out_d.modv  = (st_q == ST_MODRM);
    out_d.modrm = (st_q == ST_MODRM) ? byte_i : 8'h00;
    out_d.linv  = acc_q.lock && (acc_q.vex != VEX_NONE || !lockable ||
                  (st_q == ST_MODRM && byte_i[7:6] == 2'b11));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PFX;
      acc_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      out_q   <= '0;
      tl_q    <= 1'b0;
      len_q   <= '0;
    end else begin
      out_v_q <= emit || abort;
      if (abort) begin
        out_q <= '0;
        tl_q  <= 1'b1;
        len_q <= CNT_W'(MAX_LEN);
      end else if (emit) begin
        out_q <= out_d;
        tl_q  <= 1'b0;
        len_q <= (st_q == ST_MODRM) ? cnt_q : cnt_n;
      end
    end
  end

  assign out_valid_o    = out_v_q;
  assign opcode_o       = out_q.opc;
  assign seg_o          = out_q.sum.seg;
  assign rep_o          = out_q.sum.rep;
  assign lock_o         = out_q.sum.lock;
  assign lock_invalid_o = out_q.linv;
  assign rep_ignored_o  = out_q.rign;
  assign pause_o        = out_q.pau;
  assign branch_hint_o  = out_q.hint;
  assign opsize_o       = out_q.sum.osz;
  assign addrsize_o     = out_q.sum.asz;
  assign rex_vld_o      = out_q.sum.rexv;
  assign rex_o          = out_q.sum.rex;
  assign vex_o          = out_q.sum.vex;
  assign vex_payload_o  = out_q.sum.pay;
  assign modrm_vld_o    = out_q.modv;
  assign modrm_o        = out_q.modrm;
  assign len_o          = len_q;
  assign too_long_o     = tl_q;
endmodule

// File: rtl/prefix_scanner_chk.sv
module prefix_scanner_chk #(
  parameter int unsigned MAX_LEN = 15,
  localparam int unsigned CNT_W  = $clog2(MAX_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             out_valid_o,
  input logic [7:0]       opcode_o,
  input logic [2:0]       seg_o,
  input logic [1:0]       rep_o,
  input logic             lock_o,
  input logic             lock_invalid_o,
  input logic             rep_ignored_o,
  input logic             pause_o,
  input logic             branch_hint_o,
  input logic             rex_vld_o,
  input logic [1:0]       vex_o,
  input logic             modrm_vld_o,
  input logic [CNT_W-1:0] len_o,
  input logic             too_long_o
);
  // R12
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(valid_i));
  // R11
  too_long_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && too_long_o) |-> (len_o == CNT_W'(MAX_LEN) && !lock_o && opcode_o == 8'h00));
  // R11
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (len_o != '0 && len_o <= CNT_W'(MAX_LEN)));
  // R7
  pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pause_o) |-> (opcode_o == 8'h90 && rep_o == 2'd2 && !rep_ignored_o));
  // R8
  hint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && branch_hint_o) |-> (opcode_o[7:4] == 4'h7 && seg_o == 3'd0));
  // R9
  lock_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && lock_invalid_o) |-> lock_o);
  // R10
  modrm_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && modrm_vld_o) |-> (lock_o && vex_o == 2'd0));
  // R5
  rex_vex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && vex_o != 2'd0) |-> !rex_vld_o);
endmodule

bind prefix_scanner prefix_scanner_chk #(.MAX_LEN(MAX_LEN)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .out_valid_o    (out_valid_o),
  .opcode_o       (opcode_o),
  .seg_o          (seg_o),
  .rep_o          (rep_o),
  .lock_o         (lock_o),
  .lock_invalid_o (lock_invalid_o),
  .rep_ignored_o  (rep_ignored_o),
  .pause_o        (pause_o),
  .branch_hint_o  (branch_hint_o),
  .rex_vld_o      (rex_vld_o),
  .vex_o          (vex_o),
  .modrm_vld_o    (modrm_vld_o),
  .len_o          (len_o),
  .too_long_o     (too_long_o)
);

// File: tb/prefix_scanner_tb_top.sv
module prefix_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        mode64_i = 1'b1;
  logic        out_valid_o, lock_o, lock_invalid_o, rep_ignored_o, pause_o, branch_hint_o;
  logic        opsize_o, addrsize_o, rex_vld_o, modrm_vld_o, too_long_o;
  logic [7:0]  opcode_o, modrm_o;
  logic [2:0]  seg_o;
  logic [1:0]  rep_o, vex_o;
  logic [3:0]  rex_o, len_o;
  logic [15:0] vex_payload_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  prefix_scanner dut_i (
    .clk_i, .rst_ni, .valid_i, .byte_i, .mode64_i,
    .out_valid_o, .opcode_o, .seg_o, .rep_o, .lock_o, .lock_invalid_o,
    .rep_ignored_o, .pause_o, .branch_hint_o, .opsize_o, .addrsize_o,
    .rex_vld_o, .rex_o, .vex_o, .vex_payload_o, .modrm_vld_o, .modrm_o,
    .len_o, .too_long_o
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  n;
    logic [63:0] b;
    logic        m64;
    logic [7:0]  opc;
    logic [2:0]  seg;
    logic [1:0]  rep;
    logic        lk, linv, rign, pau, hint, osz, asz, rexv;
    logic [3:0]  rex;
    logic [1:0]  vex;
    logic [15:0] pay;
    logic        modv;
    logic [7:0]  modrm;
    logic [3:0]  len;
    logic        tl;
  } vec_t;

  // req, n, bytes, m64, opc, seg, rep, lk, linv, rign, pau, hint, osz, asz, rexv, rex, vex, pay, modv, modrm, len, tl
  localparam vec_t VECS [NVEC] = '{
    // R7 pause
    '{4'd7, 4'd2, 64'hF390_0000_0000_0000, 1'b1, 8'h90, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd2, 1'b0},
    // R3 F2 overrides F3, no pause
    '{4'd3, 4'd3, 64'hF3F2_9000_0000_0000, 1'b1, 8'h90, 3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd3, 1'b0},
    // R6 string op keeps rep
    '{4'd6, 4'd2, 64'hF3A4_0000_0000_0000, 1'b1, 8'hA4, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd2, 1'b0},
    // R2 last segment wins
    '{4'd2, 4'd6, 64'h2E65_6667_668B_0000, 1'b1, 8'h8B, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd6, 1'b0},
    // R8 branch hint
    '{4'd8, 4'd2, 64'h3E74_0000_0000_0000, 1'b1, 8'h74, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd2, 1'b0},
    // R4 legacy after REX clears it
    '{4'd4, 4'd3, 64'h4866_8900_0000_0000, 1'b1, 8'h89, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd3, 1'b0},
    // R4 later REX replaces
    '{4'd4, 4'd4, 64'h6641_4889_0000_0000, 1'b1, 8'h89, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h8, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd4, 1'b0},
    // R4 outside 64-bit mode 48 is an opcode
    '{4'd4, 4'd1, 64'h4800_0000_0000_0000, 1'b0, 8'h48, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd1, 1'b0},
    // R5 two-byte VEX
    '{4'd5, 4'd4, 64'h66C5_F877_0000_0000, 1'b1, 8'h77, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 2'd2, 16'h00F8, 1'b0, 8'h00, 4'd4, 1'b0},
    // R5 three-byte VEX, F0 after payload is opcode, REX dropped
    '{4'd5, 4'd5, 64'h48C4_E279_F000_0000, 1'b1, 8'hF0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd3, 16'hE279, 1'b0, 8'h00, 4'd5, 1'b0},
    // R9 lock on non-lockable
    '{4'd9, 4'd2, 64'hF090_0000_0000_0000, 1'b1, 8'h90, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd2, 1'b0},
    // R10 lock with memory operand
    '{4'd10, 4'd3, 64'hF001_0800_0000_0000, 1'b1, 8'h01, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b1, 8'h08, 4'd2, 1'b0},
    // R10 lock with register operand
    '{4'd10, 4'd3, 64'hF087_C100_0000_0000, 1'b1, 8'h87, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b1, 8'hC1, 4'd2, 1'b0},
    // R9 lock with VEX
    '{4'd9, 4'd4, 64'hF0C5_F877_0000_0000, 1'b1, 8'h77, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd2, 16'h00F8, 1'b0, 8'h00, 4'd4, 1'b0},
    // R6 repne on ret
    '{4'd6, 4'd2, 64'hF2C3_0000_0000_0000, 1'b1, 8'hC3, 3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd2, 1'b0},
    // R1 repeats accepted
    '{4'd1, 4'd6, 64'h6666_6626_26AD_0000, 1'b1, 8'hAD, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd6, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic m);
    @(negedge clk_i);
    valid_i  = 1'b1;
    byte_i   = b;
    mode64_i = m;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [63:0] act_bundle();
    return 64'({opcode_o, seg_o, rep_o, lock_o, lock_invalid_o, rep_ignored_o, pause_o,
                branch_hint_o, opsize_o, addrsize_o, rex_vld_o, rex_o, vex_o, vex_payload_o,
                modrm_vld_o, modrm_o, len_o, too_long_o});
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 reset out_valid", 64'(out_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 idle out_valid", 64'(out_valid_o), 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < int'(VECS[v].n); i++)
        send(VECS[v].b[63 - 8*i -: 8], VECS[v].m64);
      idle();
      chk($sformatf("R%0d vec%0d valid", VECS[v].req, v), 64'(out_valid_o), 64'd1);
      chk($sformatf("R%0d vec%0d fields", VECS[v].req, v), act_bundle(),
          64'({VECS[v].opc, VECS[v].seg, VECS[v].rep, VECS[v].lk, VECS[v].linv, VECS[v].rign,
               VECS[v].pau, VECS[v].hint, VECS[v].osz, VECS[v].asz, VECS[v].rexv, VECS[v].rex,
               VECS[v].vex, VECS[v].pay, VECS[v].modv, VECS[v].modrm, VECS[v].len, VECS[v].tl}));
    end

    // R11 opcode as 15th byte is legal
    for (int i = 0; i < 14; i++) send(8'h66, 1'b1);
    send(8'h90, 1'b1);
    idle();
    chk("R11 fifteen ok", 64'({out_valid_o, too_long_o, len_o, opcode_o, opsize_o}),
        64'({1'b1, 1'b0, 4'd15, 8'h90, 1'b1}));

    // R11 15th byte still a prefix
    for (int i = 0; i < 15; i++) send(8'h66, 1'b1);
    idle();
    chk("R11 abort", 64'({out_valid_o, too_long_o, len_o, opcode_o, opsize_o}),
        64'({1'b1, 1'b1, 4'd15, 8'h00, 1'b0}));

    // R12 fresh summary after abort
    send(8'hF3, 1'b1);
    send(8'h90, 1'b1);
    idle();
    chk("R12 fresh after abort", 64'({out_valid_o, pause_o, opsize_o, len_o}),
        64'({1'b1, 1'b1, 1'b0, 4'd2}));

    // R11 VEX payload landing on the limit
    for (int i = 0; i < 13; i++) send(8'h66, 1'b1);
    send(8'hC5, 1'b1);
    send(8'hF8, 1'b1);
    idle();
    chk("R11 vex abort", 64'({out_valid_o, too_long_o, len_o, vex_o}),
        64'({1'b1, 1'b1, 4'd15, 2'd0}));

    // R12 gaps with valid low are ignored
    send(8'hF3, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      byte_i  = 8'h90;
      @(posedge clk_i);
      #1;
      chk("R12 gap no output", 64'(out_valid_o), 64'd0);
    end
    send(8'h90, 1'b1);
    idle();
    chk("R12 gap result", 64'({out_valid_o, pause_o, len_o}), 64'({1'b1, 1'b1, 4'd2}));

    // R12 reset mid-run clears summary
    send(8'hF3, 1'b1);
    idle();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R12 reset mid-run", 64'(out_valid_o), 64'd0);
    rst_ni = 1'b1;
    send(8'h90, 1'b1);
    idle();
    chk("R12 after reset", 64'({out_valid_o, rep_o, pause_o, rep_ignored_o, len_o}),
        64'({1'b1, 2'd0, 1'b0, 1'b0, 4'd1}));

    // R1 pulse lasts one cycle
    idle();
    chk("R1 single pulse", 64'(out_valid_o), 64'd0);

    finish_run();
  end
endmodule